// File: doc/BRIEF.md
# Statistics Counter Dump Engine

This block keeps four frame counters for a network receive/transmit path and, on command, copies them into a statistics area in system memory. The area is written one dword at a time through a simple write master that offers an address and a 32-bit little-endian data word and holds them until the memory side accepts them. Each counter sits at a fixed byte offset inside the area. Every other dword of the area is written as zero, so software always finds the whole area rewritten. One further dword, the completion word, is written just past the end of the area. Its value tells software whether the counters were only copied or were also cleared.

The host first loads the dump address. The engine forces that address to a dword boundary. The host then issues either a plain dump or a dump-and-clear. The counters are sampled in the cycle the command is accepted. A dump-and-clear zeroes the counters in that same cycle. Counting continues while the memory writes drain, so no increment is lost.

The controller has four states. IDLE waits for a command. FILL writes the area words, lowest address first. SIGN writes the completion word. FINISH raises the done pulse for one cycle. The transitions are:
- IDLE to FILL when a dump command arrives.
- FILL to SIGN when the last area word is accepted.
- SIGN to FINISH when the completion word is accepted.
- FINISH to IDLE unconditionally.

Top module: `stats_dump_engine`

## Requirements
- R1: After reset `wr_valid` and `dump_done` are low, all counters are zero and the dump address is zero.
- R2: Loading an address stores it with bits 1:0 cleared. Every write address issued is therefore dword aligned. A load in the same cycle as a dump command applies to that dump.
- R3: A dump issues exactly AREA_BYTES/4 area writes, at base, base+4, base+8 and so on in ascending order. The first write is offered in the cycle after the command. While `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` are held unchanged.
- R4: Transmitted-good frames (`cnt_inc[0]`) are written at byte offset 0. Received-good frames (`cnt_inc[1]`) are at offset 36, receive-resource errors (`cnt_inc[2]`) at 48 and receive-short-frame errors (`cnt_inc[3]`) at 60. Every other area dword is written as 0. Counters are zero-extended to 32 bits.
- R5: After the area, one write goes to base+AREA_BYTES. Its data is 0x0000A005 for a plain dump and 0x0000A007 for a dump-and-clear.
- R6: A plain dump leaves the counters unchanged, so they keep accumulating across dumps.
- R7: A dump-and-clear zeroes every counter. Increments in the command cycle and during the dump are kept on top of the zero.
- R8: Each counter saturates at its all-ones value instead of wrapping.
- R9: `dump_done` is high for exactly one cycle. That cycle is the one following the acceptance of the completion word.
- R10: Dump commands and address loads that arrive while a dump is in progress are ignored. If a plain dump and a dump-and-clear arrive together, the dump-and-clear is taken.
- R11: The values written are the counts before the command cycle; increments presented in the command cycle are not included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_addr | input | 1 | Load `load_value` as the dump address |
| load_value | input | ADDR_W | Dump address to load |
| dump_req | input | 1 | Start a plain dump |
| dump_clr_req | input | 1 | Start a dump followed by counter clear |
| cnt_inc | input | 4 | Increment pulses, one per counter |
| wr_valid | output | 1 | Write request offered |
| wr_ready | input | 1 | Memory side accepts the write this cycle |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 32 | Little-endian dword to write |
| dump_done | output | 1 | One-cycle pulse at the end of a dump |

## Verification
Suppose a command is accepted at a clock edge. The first area write is then offered from that edge onward, and it completes one edge later at the soonest. Each later write completes at the first edge where `wr_ready` is high. `dump_done` is visible in the cycle after the edge at which the completion word was taken. The bench samples outputs and changes inputs on the falling edge, and it logs each handshake against the edge that completes it. It then compares the logged address/data sequence, the start latency (when ready is held high) and the done cycle with a reference model of the counters. That model applies its own increments, snapshot and clear at the command edge.

// File: rtl/stats_dump_pkg.sv
package stats_dump_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_SIGN   = 2'd2,
        ST_FINISH = 2'd3
    } dump_state_t;

    localparam int unsigned NUM_CNT = 4;

    localparam logic [15:0] SIGN_PLAIN = 16'hA005;
    localparam logic [15:0] SIGN_CLEAR = 16'hA007;

    // Byte offset of each counter inside the statistics area.
    function automatic int unsigned cnt_byte_offset(input int unsigned idx);
        case (idx)
            0:       return 0;
            1:       return 36;
            2:       return 48;
            default: return 60;
        endcase
    endfunction

endpackage

// File: rtl/stats_cnt_bank.sv
module stats_cnt_bank #(
    parameter int unsigned N     = 4,
    parameter int unsigned CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              inc,
    input  logic                      take,
    input  logic                      clr,
    output logic [N-1:0][CNT_W-1:0]   snap_val
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [N-1:0][CNT_W-1:0] cnt_q;

    for (genvar g = 0; g < N; g++) begin : g_cnt
        // Live counter: clear has priority, the increment of the same cycle survives it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[g] <= '0;
            end else if (clr) begin
                cnt_q[g] <= inc[g] ? CNT_W'(1) : '0;
            end else if (inc[g] && (cnt_q[g] != CNT_MAX)) begin
                cnt_q[g] <= cnt_q[g] + CNT_W'(1);
            end
        end

        // Snapshot taken at command acceptance, stable for the whole dump.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                snap_val[g] <= '0;
            end else if (take) begin
                snap_val[g] <= cnt_q[g];
            end
        end
    end

endmodule

// File: rtl/stats_dump_seq.sv
module stats_dump_seq
    import stats_dump_pkg::*;
#(
    parameter int unsigned SLOT_W    = 5,
    parameter int unsigned LAST_SLOT = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_plain,
    input  logic              start_clr,
    input  logic              wr_ready,
    output logic              idle,
    output logic              take,
    output logic              clr_cnt,
    output logic              mode_clr,
    output logic [SLOT_W-1:0] slot,
    output logic              sign_phase,
    output logic              wr_valid,
    output logic              dump_done
);

    dump_state_t state_q, state_d;
    logic        start_any;
    logic        last_slot;

    assign start_any = start_plain | start_clr;
    assign last_slot = (slot == SLOT_W'(LAST_SLOT));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_any)             state_d = ST_FILL;
            ST_FILL:   if (wr_ready && last_slot) state_d = ST_SIGN;
            ST_SIGN:   if (wr_ready)              state_d = ST_FINISH;
            ST_FINISH:                            state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        idle       = 1'b0;
        wr_valid   = 1'b0;
        sign_phase = 1'b0;
        dump_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle = 1'b1;
            ST_FILL:   wr_valid = 1'b1;
            ST_SIGN: begin
                wr_valid   = 1'b1;
                sign_phase = 1'b1;
            end
            ST_FINISH: dump_done = 1'b1;
            default:   idle = 1'b1;
        endcase
    end

    assign take    = idle & start_any;
    assign clr_cnt = idle & start_clr;

    // Slot index and dump mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot     <= '0;
            mode_clr <= 1'b0;
        end else if (take) begin
            slot     <= '0;
            mode_clr <= start_clr;
        end else if ((state_q == ST_FILL) && wr_ready && !last_slot) begin
            slot     <= slot + SLOT_W'(1);
        end
    end

endmodule

// File: rtl/stats_slot_mux.sv
module stats_slot_mux
    import stats_dump_pkg::*;
#(
    parameter int unsigned N          = 4,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned SLOT_W     = 5,
    parameter int unsigned AREA_BYTES = 80
) (
    input  logic [SLOT_W-1:0]         slot,
    input  logic [N-1:0][CNT_W-1:0]   snap_val,
    input  logic                      sign_phase,
    input  logic                      mode_clr,
    output logic [31:0]               data
);

    logic [N-1:0] hit;

    for (genvar g = 0; g < N; g++) begin : g_hit
        if (cnt_byte_offset(g) < AREA_BYTES) begin : g_in
            assign hit[g] = (slot == SLOT_W'(cnt_byte_offset(g) / 4));
        end else begin : g_out
            assign hit[g] = 1'b0;
        end
    end

    always_comb begin
        data = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (hit[i]) begin
                data = data | 32'(snap_val[i]);
            end
        end
        if (sign_phase) begin
            data = {16'h0000, (mode_clr ? SIGN_CLEAR : SIGN_PLAIN)};
        end
    end

endmodule

// File: rtl/stats_dump_engine.sv
module stats_dump_engine
    import stats_dump_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned AREA_BYTES = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_addr,
    input  logic [ADDR_W-1:0]  load_value,
    input  logic               dump_req,
    input  logic               dump_clr_req,
    input  logic [3:0]         cnt_inc,
    output logic               wr_valid,
    input  logic               wr_ready,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [31:0]        wr_data,
    output logic               dump_done
);

    localparam int unsigned AREA_WORDS = AREA_BYTES / 4;
    localparam int unsigned LAST_SLOT  = AREA_WORDS - 1;
    localparam int unsigned SLOT_W     = (AREA_WORDS > 1) ? $clog2(AREA_WORDS) : 1;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    logic                         idle;
    logic                         take;
    logic                         clr_cnt;
    logic                         mode_clr;
    logic [SLOT_W-1:0]            slot;
    logic                         sign_phase;
    logic [NUM_CNT-1:0][CNT_W-1:0] snap_val;
    logic [ADDR_W-1:0]            base_q;

    // Dump address: loads accepted only while idle, forced to dword alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load_addr && idle) begin
            base_q <= load_value & ALIGN_MASK;
        end
    end

    stats_cnt_bank #(
        .N     (NUM_CNT),
        .CNT_W (CNT_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cnt_inc),
        .take     (take),
        .clr      (clr_cnt),
        .snap_val (snap_val)
    );

    stats_dump_seq #(
        .SLOT_W    (SLOT_W),
        .LAST_SLOT (LAST_SLOT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_plain (dump_req),
        .start_clr   (dump_clr_req),
        .wr_ready    (wr_ready),
        .idle        (idle),
        .take        (take),
        .clr_cnt     (clr_cnt),
        .mode_clr    (mode_clr),
        .slot        (slot),
        .sign_phase  (sign_phase),
        .wr_valid    (wr_valid),
        .dump_done   (dump_done)
    );

    stats_slot_mux #(
        .N          (NUM_CNT),
        .CNT_W      (CNT_W),
        .SLOT_W     (SLOT_W),
        .AREA_BYTES (AREA_BYTES)
    ) u_mux (
        .slot       (slot),
        .snap_val   (snap_val),
        .sign_phase (sign_phase),
        .mode_clr   (mode_clr),
        .data       (wr_data)
    );

    assign wr_addr = sign_phase ? (base_q + ADDR_W'(AREA_BYTES))
                                : (base_q + ADDR_W'({slot, 2'b00}));

endmodule

// File: rtl/stats_dump_engine_chk.sv
module stats_dump_engine_chk #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned AREA_BYTES = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              dump_done,
    input logic              sign_phase
);

    // R3: an offered write stays unchanged until accepted
    a_r3_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R2: every write address is dword aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    // R5: completion word carries one of the two signatures
    a_r5_sign_value: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && sign_phase) |-> ((wr_data == 32'h0000A005) || (wr_data == 32'h0000A007)));

    // R9: done follows an accepted completion word
    a_r9_done_after_sign: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done |-> $past(sign_phase && wr_valid && wr_ready));

    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done |=> !dump_done);

    // R9: no write is offered in the done cycle
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dump_done |-> !wr_valid);

endmodule

bind stats_dump_engine stats_dump_engine_chk #(
    .ADDR_W     (ADDR_W),
    .AREA_BYTES (AREA_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .dump_done  (dump_done),
    .sign_phase (sign_phase)
);

// File: tb/stats_dump_engine_test.sv
module stats_dump_engine_test;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned CNT_W      = 8;
    localparam int unsigned AREA_BYTES = 80;
    localparam int unsigned WORDS      = AREA_BYTES / 4;
    localparam int unsigned CNT_MAX    = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_addr = 1'b0;
    logic [31:0] load_value = '0;
    logic        dump_req = 1'b0;
    logic        dump_clr_req = 1'b0;
    logic [3:0]  cnt_inc = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        dump_done;

    stats_dump_engine #(
        .ADDR_W     (32),
        .CNT_W      (CNT_W),
        .AREA_BYTES (AREA_BYTES)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_addr    (load_addr),
        .load_value   (load_value),
        .dump_req     (dump_req),
        .dump_clr_req (dump_clr_req),
        .cnt_inc      (cnt_inc),
        .wr_valid     (wr_valid),
        .wr_ready     (wr_ready),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .dump_done    (dump_done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;

    // Reference model
    int unsigned exp_cnt [4];
    int unsigned exp_snap[4];
    logic [31:0] exp_base = '0;
    logic [31:0] dump_base = '0;
    bit          exp_clr = 1'b0;
    bit          eng_idle = 1'b1;
    bit          idle_next = 1'b0;

    // Observation log
    logic [31:0] wa[32];
    logic [31:0] wd[32];
    int          nw = 0;
    int          done_cnt = 0;
    int          tcount = 0;
    int          cmd_tick = 0;
    int          first_tick = 0;
    int          last_tick = 0;
    int          done_tick = 0;
    int          inc_pct = 0;
    bit          force_ready = 1'b1;
    bit          inc_all = 1'b0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_slot(input int k);
        case (k)
            0:       return 32'(exp_snap[0]);
            9:       return 32'(exp_snap[1]);
            12:      return 32'(exp_snap[2]);
            15:      return 32'(exp_snap[3]);
            default: return 32'h0;
        endcase
    endfunction

    // One cycle: observe, drive new inputs and update the model, all at the falling edge.
    task automatic tick(input bit ld, input logic [31:0] ld_val, input bit dp, input bit dc);
        @(negedge clk);
        tcount++;
        if (idle_next) begin
            eng_idle  = 1'b1;
            idle_next = 1'b0;
        end
        if (dump_done) begin
            done_cnt++;
            done_tick = tcount;
            idle_next = 1'b1;
        end
        wr_ready = force_ready ? 1'b1 : ($urandom_range(3) != 0);
        if (wr_valid && wr_ready) begin
            if (nw < 32) begin
                wa[nw] = wr_addr;
                wd[nw] = wr_data;
            end
            if (nw == 0) first_tick = tcount;
            last_tick = tcount;
            nw++;
        end
        for (int i = 0; i < 4; i++) begin
            cnt_inc[i] = inc_all || ((inc_pct > 0) && ($urandom_range(99) < inc_pct));
        end
        load_addr    = ld;
        load_value   = ld_val;
        dump_req     = dp;
        dump_clr_req = dc;
        if (eng_idle) begin
            if (ld) exp_base = ld_val & 32'hFFFF_FFFC;
            if (dp || dc) begin
                exp_snap  = exp_cnt;
                exp_clr   = dc;
                dump_base = exp_base;
                cmd_tick  = tcount;
                eng_idle  = 1'b0;
                if (dc) begin
                    for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
                end
            end
        end
        for (int i = 0; i < 4; i++) begin
            if (cnt_inc[i] && (exp_cnt[i] < CNT_MAX)) exp_cnt[i]++;
        end
    endtask

    task automatic run_dump(input bit ld, input logic [31:0] addr, input bit plain,
                            input bit clr, input bit inject, input string tag);
        nw = 0;
        done_cnt = 0;
        tick(ld, addr, plain, clr);
        for (int k = 0; k < 400 && !eng_idle; k++) begin
            if (inject && (k == 3)) tick(1'b1, 32'hDEAD_BEE8, 1'b1, 1'b1);
            else                    tick(1'b0, 32'h0, 1'b0, 1'b0);
        end
        repeat (3) tick(1'b0, 32'h0, 1'b0, 1'b0);

        chk(nw == WORDS + 1, {"R3/R10 write count ", tag}, nw, WORDS + 1);
        for (int k = 0; k < int'(WORDS); k++) begin
            chk(wa[k] == dump_base + 32'(4 * k), {"R2/R3 address ", tag}, wa[k], dump_base + 32'(4 * k));
            chk(wd[k] == exp_slot(k), {"R4/R11 data ", tag}, wd[k], exp_slot(k));
        end
        chk(wa[WORDS] == dump_base + AREA_BYTES, {"R5 completion address ", tag},
            wa[WORDS], dump_base + AREA_BYTES);
        chk(wd[WORDS] == (exp_clr ? 32'hA007 : 32'hA005), {"R5 completion word ", tag},
            wd[WORDS], exp_clr ? 32'hA007 : 32'hA005);
        chk(done_cnt == 1, {"R9 done pulse count ", tag}, done_cnt, 1);
        chk(done_tick == last_tick + 1, {"R9 done timing ", tag}, done_tick, last_tick + 1);
        if (force_ready) begin
            chk(first_tick == cmd_tick + 1, {"R3 start latency ", tag}, first_tick, cmd_tick + 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        tick(1'b0, 32'h0, 1'b0, 1'b0);
        chk(wr_valid == 1'b0, "R1 valid low after reset", wr_valid, 0);
        chk(dump_done == 1'b0, "R1 done low after reset", dump_done, 0);

        // R1: first dump without load goes to address zero with zero counters
        run_dump(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R1");

        // R2/R4: unaligned load, counts accumulated, random ready
        inc_pct = 40;
        repeat (50) tick(1'b0, 32'h0, 1'b0, 1'b0);
        force_ready = 1'b0;
        run_dump(1'b1, 32'h1000_0013, 1'b1, 1'b0, 1'b0, "R2");

        // R6: plain dump did not clear
        repeat (20) tick(1'b0, 32'h0, 1'b0, 1'b0);
        run_dump(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R6");

        // R7: dump-and-clear with increments during the dump, then a plain dump
        run_dump(1'b1, 32'h0000_2002, 1'b0, 1'b1, 1'b0, "R7");
        run_dump(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R7 after");

        // R10: commands and loads during a dump are ignored
        run_dump(1'b1, 32'h0000_4000, 1'b1, 1'b0, 1'b1, "R10 busy");
        run_dump(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R10 base kept");

        // R10: both commands together take the clearing one
        force_ready = 1'b1;
        run_dump(1'b0, 32'h0, 1'b1, 1'b1, 1'b0, "R10 both");

        // R8: saturation
        inc_pct = 0;
        inc_all = 1'b1;
        repeat (300) tick(1'b0, 32'h0, 1'b0, 1'b0);
        inc_all = 1'b0;
        run_dump(1'b0, 32'h0, 1'b1, 1'b0, 1'b0, "R8");
        chk(exp_snap[0] == CNT_MAX, "R8 model saturated", exp_snap[0], CNT_MAX);

        // Random dumps; R11 covered by increments in command cycles
        for (int it = 0; it < 8; it++) begin
            inc_pct = 30;
            force_ready = ($urandom_range(1) == 0);
            repeat ($urandom_range(30)) tick(1'b0, 32'h0, 1'b0, 1'b0);
            if ($urandom_range(1) == 0)
                run_dump(1'b1, $urandom, 1'b1, 1'b0, 1'b0, "R11 random");
            else
                run_dump(1'b1, $urandom, 1'b0, 1'b1, 1'b0, "R7 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule